// File: doc/BRIEF.md
# Receiver Polling-Mode Power Sequencer

A control state machine for a low-power radio receiver that wakes up periodically to look for a transmitter. Between looks the receiver sleeps with only its oscillator and this sequencer running. On waking it optionally brings up the synthesizer loop, waits for the analog signal path to settle, and then hands control to an external demodulator. That demodulator judges the incoming bit timing and reports the outcome through single-cycle strobes. Every timed interval counts pulses of a basic data-clock tick (`tick_i`), not raw clock cycles.

A good bit check raises one-cycle set requests for three control bits kept elsewhere: data output enable, clock output enable and operating mode. The sequencer then waits for a start bit and moves into receive, where demodulated data is routed to the data buffer. A failed check puts the receiver back to sleep. A bit error after a good check sends it back through start-up. If that error arrives before the start bit and interrupts are not masked by the polling flag, the sequencer also raises an interrupt.

Top module: `rxpoll_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in sleep. While `rst` is held, `rx_active_o`, `irq_o`, `rx_route_o` and all three set outputs are 0.
- R2: `rx_active_o` is 0 exactly while the block sleeps and 1 in every other state. `rx_route_o` and the set outputs are never 1 while it is 0.
- R3: Sleep lasts `sleep_val_i` × SLEEP_UNIT ticks, multiplied by SLEEP_XMUL when `sleep_ext_i` is 1. The value is captured on entry to sleep. A sleep value of 0 leaves sleep on the first clock edge.
- R4: On leaving sleep, or on returning to start-up after a bit error, synthesizer start-up (PLL_TICKS ticks) runs only when `opmode_i` is 0. When `opmode_i` is 1 the block goes straight to signal-path start-up.
- R5: Signal-path start-up lasts SIG_TICKS[`baud_sel_i`] ticks: index 0 to 3 selects 882, 498, 306 or 210 ticks by default.
- R6: `chk_ok_i` during bit check produces a one-cycle pulse on `set_vout_o`, `set_clk_o` and `set_opmode_o` together, and the block then waits for a start bit. Check strobes in sleep and start-up have no effect.
- R7: `chk_fail_i` during bit check sends the block to sleep, or to signal-path start-up when `sleep_val_i` is 0. Fail takes priority over a simultaneous ok.
- R8: `bit_err_i` while waiting for the start bit returns the block to start-up. The error also produces a one-cycle `irq_o` pulse, but only if `pmode_i` is 0. Error takes priority over a simultaneous start bit.
- R9: `start_bit_i` while waiting enters receive. `rx_route_o` is 1 for exactly the receive state.
- R10: `bit_err_i` in receive returns the block to start-up without raising `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Basic data-clock tick strobe |
| sleep_val_i | input | SLEEP_W | Sleep length in units of SLEEP_UNIT ticks |
| sleep_ext_i | input | 1 | Multiply sleep length by SLEEP_XMUL |
| baud_sel_i | input | 2 | Baud-range index for signal-path start-up |
| opmode_i | input | 1 | Current operating-mode bit; 1 skips synthesizer start-up |
| pmode_i | input | 1 | Polling flag; 1 masks the early-error interrupt |
| chk_ok_i | input | 1 | Demodulator strobe: bit check passed |
| chk_fail_i | input | 1 | Demodulator strobe: bit check failed |
| start_bit_i | input | 1 | Demodulator strobe: start bit seen |
| bit_err_i | input | 1 | Demodulator strobe: bit error |
| rx_active_o | output | 1 | Receiver awake |
| irq_o | output | 1 | One-cycle interrupt pulse |
| set_vout_o | output | 1 | Set request for data output enable |
| set_clk_o | output | 1 | Set request for clock output enable |
| set_opmode_o | output | 1 | Set request for operating-mode bit |
| rx_route_o | output | 1 | Demodulated data routed to buffer (receive state) |

## Verification
The bench shrinks the block to SLEEP_W=3, SLEEP_UNIT=4, SLEEP_XMUL=3, PLL_TICKS=6 and SIG_TICKS of 9, 7, 5 and 3. This keeps every sleep and start-up interval under a hundred ticks, so all sleep values, both extension settings and all four baud ranges can be covered in a short run. A unit of 4 takes the shift variant of the sleep scaler, and a factor of 3 takes the multiplier variant. Together they exercise both generate branches. Ticks arrive at random densities, so the bench checks interval lengths in ticks rather than clock cycles.

// File: rtl/rxpoll_pkg.sv
package rxpoll_pkg;

   typedef enum logic [2:0] {
      ST_SLEEP = 3'd0,
      ST_PLL   = 3'd1,
      ST_SIG   = 3'd2,
      ST_CHECK = 3'd3,
      ST_WAIT  = 3'd4,
      ST_RECV  = 3'd5
   } seq_state_e;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rxpoll_dursel.sv
module rxpoll_dursel
   import rxpoll_pkg::*;
#(
   parameter int SLEEP_W      = 5,
   parameter int SLEEP_UNIT   = 1024,
   parameter int SLEEP_XMUL   = 8,
   parameter int PLL_TICKS    = 799,
   parameter int SIG_TICKS [4] = '{882, 498, 306, 210},
   parameter int CNT_W        = 18
) (
   input  seq_state_e         tgt_st,
   input  logic [SLEEP_W-1:0] sleep_val,
   input  logic               sleep_ext,
   input  logic [1:0]         baud_sel,
   output logic [CNT_W-1:0]   dur
);

   localparam int UNIT_LG = $clog2(SLEEP_UNIT);
   localparam int XMUL_LG = $clog2(SLEEP_XMUL);

   // elaboration-time parameter checks
   if (SLEEP_W < 1)    begin : g_bad_sw   $error("SLEEP_W must be at least 1");    end
   if (SLEEP_UNIT < 1) begin : g_bad_unit $error("SLEEP_UNIT must be at least 1"); end
   if (SLEEP_XMUL < 1) begin : g_bad_xmul $error("SLEEP_XMUL must be at least 1"); end
   if (PLL_TICKS < 1)  begin : g_bad_pll  $error("PLL_TICKS must be at least 1");  end

   logic [CNT_W-1:0] slp_base;
   logic [CNT_W-1:0] slp_ext;
   logic [CNT_W-1:0] sig_tab [4];

   // sleep unit scaling: shift when a power of two, multiply otherwise
   if ((1 << UNIT_LG) == SLEEP_UNIT) begin : g_unit_shift
      assign slp_base = CNT_W'(sleep_val) << UNIT_LG;
   end else begin : g_unit_mul
      assign slp_base = CNT_W'(sleep_val) * CNT_W'(SLEEP_UNIT);
   end

   // extension factor, same choice
   if ((1 << XMUL_LG) == SLEEP_XMUL) begin : g_xmul_shift
      assign slp_ext = slp_base << XMUL_LG;
   end else begin : g_xmul_mul
      assign slp_ext = slp_base * CNT_W'(SLEEP_XMUL);
   end

   // per-baud-range settle table
   for (genvar g = 0; g < 4; g++) begin : g_sig
      if (SIG_TICKS[g] < 1) begin : g_bad_sig
         $error("SIG_TICKS entries must be at least 1");
      end
      assign sig_tab[g] = CNT_W'(SIG_TICKS[g]);
   end

   always_comb begin
      unique case (tgt_st)
         ST_SLEEP: dur = sleep_ext ? slp_ext : slp_base;
         ST_PLL:   dur = CNT_W'(PLL_TICKS);
         ST_SIG:   dur = sig_tab[baud_sel];
         default:  dur = '0;
      endcase
   end

endmodule

// File: rtl/rxpoll_timer.sv
module rxpoll_timer #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   // reload on reset and on every state entry; count ticks down to one
   always_ff @(posedge clk) begin
      if (rst || load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // zero length expires at once; otherwise the last tick ends the interval
   assign expire = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && tick);

endmodule

// File: rtl/rxpoll_fsm.sv
module rxpoll_fsm
   import rxpoll_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       expire,
   input  logic       opmode,
   input  logic       pmode,
   input  logic       sleep_zero,
   input  logic       chk_ok,
   input  logic       chk_fail,
   input  logic       start_bit,
   input  logic       bit_err,
   output seq_state_e st_q,
   output seq_state_e nxt_st,
   output logic       load,
   output logic       irq_q,
   output logic       set_q
);

   seq_state_e nxt_raw;
   seq_state_e wake_st;
   logic       irq_d;
   logic       set_d;

   // start-up entry: synthesizer loop only when the mode bit is clear
   assign wake_st = opmode ? ST_SIG : ST_PLL;

   always_comb begin
      nxt_raw = st_q;
      irq_d   = 1'b0;
      set_d   = 1'b0;
      unique case (st_q)
         ST_SLEEP: if (expire) nxt_raw = wake_st;
         ST_PLL:   if (expire) nxt_raw = ST_SIG;
         ST_SIG:   if (expire) nxt_raw = ST_CHECK;
         ST_CHECK: begin
            if (chk_fail) begin
               nxt_raw = sleep_zero ? ST_SIG : ST_SLEEP;
            end else if (chk_ok) begin
               nxt_raw = ST_WAIT;
               set_d   = 1'b1;
            end
         end
         ST_WAIT: begin
            if (bit_err) begin
               nxt_raw = wake_st;
               irq_d   = !pmode;
            end else if (start_bit) begin
               nxt_raw = ST_RECV;
            end
         end
         ST_RECV:  if (bit_err) nxt_raw = wake_st;
         default:  nxt_raw = ST_SLEEP;
      endcase
   end

   assign nxt_st = rst ? ST_SLEEP : nxt_raw;
   assign load   = rst || (nxt_raw != st_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_SLEEP;
         irq_q <= 1'b0;
         set_q <= 1'b0;
      end else begin
         st_q  <= nxt_raw;
         irq_q <= irq_d;
         set_q <= set_d;
      end
   end

endmodule

// File: rtl/rxpoll_seq.sv
module rxpoll_seq
   import rxpoll_pkg::*;
#(
   parameter int SLEEP_W      = 5,
   parameter int SLEEP_UNIT   = 1024,
   parameter int SLEEP_XMUL   = 8,
   parameter int PLL_TICKS    = 799,
   parameter int SIG_TICKS [4] = '{882, 498, 306, 210}
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick_i,
   input  logic [SLEEP_W-1:0] sleep_val_i,
   input  logic               sleep_ext_i,
   input  logic [1:0]         baud_sel_i,
   input  logic               opmode_i,
   input  logic               pmode_i,
   input  logic               chk_ok_i,
   input  logic               chk_fail_i,
   input  logic               start_bit_i,
   input  logic               bit_err_i,
   output logic               rx_active_o,
   output logic               irq_o,
   output logic               set_vout_o,
   output logic               set_clk_o,
   output logic               set_opmode_o,
   output logic               rx_route_o
);

   localparam int SLP_MAX = ((1 << SLEEP_W) - 1) * SLEEP_UNIT * SLEEP_XMUL;
   localparam int SIG_MAX = max_of4(SIG_TICKS[0], SIG_TICKS[1], SIG_TICKS[2], SIG_TICKS[3]);
   localparam int DUR_MAX = max_of4(SLP_MAX, PLL_TICKS, SIG_MAX, 1);
   localparam int CNT_W   = $clog2(DUR_MAX + 1);

   seq_state_e       cur_st;
   seq_state_e       nxt_st;
   logic             load;
   logic             expire;
   logic             irq_q;
   logic             set_q;
   logic [CNT_W-1:0] dur;

   rxpoll_dursel #(
      .SLEEP_W    (SLEEP_W),
      .SLEEP_UNIT (SLEEP_UNIT),
      .SLEEP_XMUL (SLEEP_XMUL),
      .PLL_TICKS  (PLL_TICKS),
      .SIG_TICKS  (SIG_TICKS),
      .CNT_W      (CNT_W)
   ) u_dursel (
      .tgt_st    (nxt_st),
      .sleep_val (sleep_val_i),
      .sleep_ext (sleep_ext_i),
      .baud_sel  (baud_sel_i),
      .dur       (dur)
   );

   rxpoll_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (dur),
      .tick     (tick_i),
      .expire   (expire)
   );

   rxpoll_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .expire     (expire),
      .opmode     (opmode_i),
      .pmode      (pmode_i),
      .sleep_zero (sleep_val_i == '0),
      .chk_ok     (chk_ok_i),
      .chk_fail   (chk_fail_i),
      .start_bit  (start_bit_i),
      .bit_err    (bit_err_i),
      .st_q       (cur_st),
      .nxt_st     (nxt_st),
      .load       (load),
      .irq_q      (irq_q),
      .set_q      (set_q)
   );

   assign rx_active_o  = (cur_st != ST_SLEEP);
   assign rx_route_o   = (cur_st == ST_RECV);
   assign irq_o        = irq_q;
   assign set_vout_o   = set_q;
   assign set_clk_o    = set_q;
   assign set_opmode_o = set_q;

endmodule

// File: rtl/rxpoll_chk.sv
module rxpoll_chk
   import rxpoll_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input seq_state_e st,
   input logic       pmode_i,
   input logic       chk_ok_i,
   input logic       chk_fail_i,
   input logic       start_bit_i,
   input logic       bit_err_i,
   input logic       rx_active_o,
   input logic       irq_o,
   input logic       set_vout_o,
   input logic       rx_route_o
);

   // R1: first cycle out of reset shows the quiet reset values
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!irq_o && !set_vout_o && !rx_route_o && (st == ST_SLEEP)));

   // R2: routing and set requests only while awake
   a_r2_route_awake: assert property (@(posedge clk) disable iff (rst)
      rx_route_o |-> rx_active_o);
   a_r2_set_awake: assert property (@(posedge clk) disable iff (rst)
      set_vout_o |-> rx_active_o);

   // R6: set pulse only follows a passing check
   a_r6_set_from_check: assert property (@(posedge clk) disable iff (rst)
      set_vout_o |-> $past(st == ST_CHECK && chk_ok_i && !chk_fail_i));

   // R7: a failing check always leaves bit check without set pulse
   a_r7_fail_leaves: assert property (@(posedge clk) disable iff (rst)
      (st == ST_CHECK && chk_fail_i) |=> (st != ST_CHECK && !set_vout_o));

   // R8: interrupt is single-cycle, unmasked, and comes from an early error
   a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
      irq_o |=> !irq_o);
   a_r8_irq_unmasked: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> !$past(pmode_i));
   a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> $past(st == ST_WAIT && bit_err_i));

   // R9: receive is entered only on a clean start bit
   a_r9_route_start: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_route_o) |-> $past(start_bit_i && !bit_err_i));

   // R10: error in receive leaves it without interrupt
   a_r10_recv_err: assert property (@(posedge clk) disable iff (rst)
      (st == ST_RECV && bit_err_i) |=> (!irq_o && !rx_route_o));

endmodule

bind rxpoll_seq rxpoll_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .st          (cur_st),
   .pmode_i     (pmode_i),
   .chk_ok_i    (chk_ok_i),
   .chk_fail_i  (chk_fail_i),
   .start_bit_i (start_bit_i),
   .bit_err_i   (bit_err_i),
   .rx_active_o (rx_active_o),
   .irq_o       (irq_o),
   .set_vout_o  (set_vout_o),
   .rx_route_o  (rx_route_o)
);

// File: tb/rxpoll_seq_bench.sv
module rxpoll_seq_bench;

   localparam int CLK_NS = 10;
   localparam int SW     = 3;
   localparam int UNIT   = 4;
   localparam int XMUL   = 3;
   localparam int PLLT   = 6;
   localparam int SIGT [4] = '{9, 7, 5, 3};
   localparam int LIM    = 3000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick_i = 1'b0;
   logic [SW-1:0] sleep_val_i = '0;
   logic          sleep_ext_i = 1'b0;
   logic [1:0]    baud_sel_i = 2'd0;
   logic          opmode_i = 1'b0;
   logic          pmode_i = 1'b0;
   logic          chk_ok_i = 1'b0;
   logic          chk_fail_i = 1'b0;
   logic          start_bit_i = 1'b0;
   logic          bit_err_i = 1'b0;
   logic          rx_active_o, irq_o, set_vout_o, set_clk_o, set_opmode_o, rx_route_o;

   rxpoll_seq #(
      .SLEEP_W (SW), .SLEEP_UNIT (UNIT), .SLEEP_XMUL (XMUL),
      .PLL_TICKS (PLLT), .SIG_TICKS (SIGT)
   ) u_rxpoll_seq (
      .clk (clk), .rst (rst), .tick_i (tick_i),
      .sleep_val_i (sleep_val_i), .sleep_ext_i (sleep_ext_i), .baud_sel_i (baud_sel_i),
      .opmode_i (opmode_i), .pmode_i (pmode_i),
      .chk_ok_i (chk_ok_i), .chk_fail_i (chk_fail_i),
      .start_bit_i (start_bit_i), .bit_err_i (bit_err_i),
      .rx_active_o (rx_active_o), .irq_o (irq_o),
      .set_vout_o (set_vout_o), .set_clk_o (set_clk_o), .set_opmode_o (set_opmode_o),
      .rx_route_o (rx_route_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   dens = 1;
   logic s_rx, s_irq, s_set, s_route, s_tick;
   logic [2:0] s_set3;

   function automatic int f_sleep(input int v, input bit ext);
      return v * UNIT * (ext ? XMUL : 1);
   endfunction

   function automatic int f_start(input bit op, input int b);
      return (op ? 0 : PLLT) + SIGT[b];
   endfunction

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic ceq(input string rq, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // one cycle: sample outputs at the falling edge, then drive this cycle's tick
   task automatic tk();
      @(negedge clk);
      s_rx    = rx_active_o;
      s_irq   = irq_o;
      s_set   = set_vout_o;
      s_set3  = {set_vout_o, set_clk_o, set_opmode_o};
      s_route = rx_route_o;
      if (rst) s_tick = 1'b0;
      else if (dens <= 1) s_tick = 1'b1;
      else s_tick = ($urandom_range(dens - 1) == 0);
      tick_i = s_tick;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      chk_ok_i = 0; chk_fail_i = 0; start_bit_i = 0; bit_err_i = 0;
      repeat (3) tk();
      ceq("R1 rx_active in reset", int'(s_rx), 0);
      ceq("R1 irq in reset", int'(s_irq), 0);
      ceq("R1 set outputs in reset", int'(s_set3), 0);
      ceq("R1 route in reset", int'(s_route), 0);
      rst = 1'b0;
   endtask

   task automatic wait_rise(input int n0, input int sum0, output int n, output int sum);
      bit to;
      bit early;
      n = n0; sum = sum0; to = 1'b1; early = 1'b0;
      for (int i = 0; i < LIM; i++) begin
         tk();
         if (s_rx) begin to = 1'b0; break; end
         if (s_set || s_route || s_irq) early = 1'b1;
         n++;
         sum += int'(s_tick);
      end
      ceq("R3 sleep ended", int'(to), 0);
      ceq("R2 outputs quiet while asleep", int'(early), 0);
   endtask

   // current sample is the first start-up sample; returns ticks before bit check
   task automatic wait_set(output int excl, output int irqs);
      int sum, last;
      bit to, dropped;
      sum = int'(s_tick); last = int'(s_tick); to = 1'b1; dropped = 1'b0; irqs = 0;
      for (int i = 0; i < LIM; i++) begin
         tk();
         if (s_set) begin to = 1'b0; break; end
         if (!s_rx) dropped = 1'b1;
         if (s_irq) irqs++;
         sum += int'(s_tick); last = int'(s_tick);
      end
      excl = sum - last;
      ceq("R6 set pulse arrived", int'(to), 0);
      ceq("R2 stayed active through start-up", int'(dropped), 0);
      ceq("R6 three set outputs together", int'(s_set3), 7);
   endtask

   task automatic wait_fall(output int excl, output bit sawset);
      int sum, last;
      bit to;
      sum = int'(s_tick); last = int'(s_tick); to = 1'b1; sawset = 1'b0;
      for (int i = 0; i < LIM; i++) begin
         tk();
         if (!s_rx) begin to = 1'b0; break; end
         if (s_set) sawset = 1'b1;
         sum += int'(s_tick); last = int'(s_tick);
      end
      excl = sum - last;
      ceq("R7 returned to sleep", int'(to), 0);
   endtask

   task automatic chk_sleep(input int n, input int sum, input int d, input string rq);
      if (d == 0) ceq(rq, n, 0);
      else ceq(rq, sum, d);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      report();
      $finish;
   end

   initial begin
      int n, sum, excl, irqs, unused_seed;
      bit sawset, bad;
      unused_seed = $urandom(32'h1d5e);

      // directed: plain wake-up, early error with interrupt
      sleep_val_i = 3'd3; sleep_ext_i = 0; baud_sel_i = 0; opmode_i = 0; pmode_i = 0; dens = 1;
      do_reset();
      chk_ok_i = 1;
      wait_rise(0, 0, n, sum);
      chk_sleep(n, sum, f_sleep(3, 0), "R3 sleep length v=3");
      wait_set(excl, irqs);
      ceq("R4 R5 start-up with synthesizer, range 0", excl, f_start(0, 0));
      chk_ok_i = 0;
      bit_err_i = 1; tk(); bit_err_i = 0;
      ceq("R8 irq on early error", int'(s_irq), 1);
      ceq("R8 back in start-up", int'(s_rx), 1);
      chk_ok_i = 1;
      wait_set(excl, irqs);
      ceq("R8 irq is one cycle", irqs, 0);
      ceq("R4 restart after error", excl, f_start(0, 0));
      chk_ok_i = 0;

      // directed: mode bit set skips synthesizer, range 3
      sleep_val_i = 3'd1; opmode_i = 1; baud_sel_i = 3; dens = 2;
      do_reset();
      chk_ok_i = 1;
      wait_rise(0, 0, n, sum);
      chk_sleep(n, sum, f_sleep(1, 0), "R3 sleep length v=1");
      wait_set(excl, irqs);
      ceq("R4 synthesizer skipped", excl, f_start(1, 3));
      chk_ok_i = 0;

      // directed: failed check with fail and ok together, extended sleep
      sleep_val_i = 3'd2; sleep_ext_i = 1; opmode_i = 0; baud_sel_i = 1; dens = 3;
      do_reset();
      chk_ok_i = 1; chk_fail_i = 1;
      wait_rise(0, 0, n, sum);
      chk_sleep(n, sum, f_sleep(2, 1), "R3 extended sleep");
      wait_fall(excl, sawset);
      ceq("R7 fail reached after full start-up", excl, f_start(0, 1));
      ceq("R7 fail wins over ok", int'(sawset), 0);
      wait_rise(1, int'(s_tick), n, sum);
      chk_sleep(n, sum, f_sleep(2, 1), "R7 sleep after fail");
      chk_fail_i = 0;
      wait_set(excl, irqs);
      ceq("R6 ok after repeated wake", excl, f_start(0, 1));
      chk_ok_i = 0;

      // directed: zero sleep value, fail loops in start-up
      sleep_val_i = 3'd0; sleep_ext_i = 0; baud_sel_i = 2; dens = 1;
      do_reset();
      wait_rise(0, 0, n, sum);
      chk_sleep(n, sum, 0, "R3 zero sleep");
      chk_fail_i = 1;
      bad = 0;
      repeat (60) begin tk(); if (!s_rx || s_set) bad = 1; end
      ceq("R7 zero sleep stays awake on fail", int'(bad), 0);
      chk_fail_i = 0; chk_ok_i = 1;
      bad = 1;
      repeat (40) begin tk(); if (s_set) bad = 0; end
      ceq("R7 ok accepted after fail loop", int'(bad), 0);
      chk_ok_i = 0;

      // random: sleep, ranges, modes, tick density and exit path
      for (int it = 0; it < 24; it++) begin
         int v, b, path;
         bit ext, op, pm, both;
         v = $urandom_range(7); ext = $urandom_range(1); b = $urandom_range(3);
         op = $urandom_range(1); pm = $urandom_range(1); path = $urandom_range(1);
         both = $urandom_range(1);
         dens = $urandom_range(1, 4);
         sleep_val_i = SW'(v); sleep_ext_i = ext; baud_sel_i = 2'(b);
         opmode_i = op; pmode_i = pm;
         do_reset();
         chk_ok_i = 1;
         wait_rise(0, 0, n, sum);
         chk_sleep(n, sum, f_sleep(v, ext), "R3 random sleep");
         wait_set(excl, irqs);
         ceq("R5 random start-up", excl, f_start(op, b));
         chk_ok_i = 0;
         if (path == 0) begin
            bit_err_i = 1; start_bit_i = both; tk(); bit_err_i = 0; start_bit_i = 0;
            ceq("R8 irq follows polling flag", int'(s_irq), int'(!pm));
            ceq("R8 error wins over start bit", int'(s_route), 0);
         end else begin
            start_bit_i = 1; tk(); start_bit_i = 0;
            ceq("R9 receive entered", int'(s_route), 1);
            repeat ($urandom_range(3)) tk();
            ceq("R9 receive held", int'(s_route), 1);
            bit_err_i = 1; tk(); bit_err_i = 0;
            ceq("R10 receive left on error", int'(s_route), 0);
            ceq("R10 no irq from receive", int'(s_irq), 0);
            ceq("R10 still active", int'(s_rx), 1);
         end
         chk_ok_i = 1;
         wait_set(excl, irqs);
         ceq("R4 start-up after error", excl, f_start(op, b));
         chk_ok_i = 0;
      end

      report();
      $finish;
   end

endmodule